// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address stream for a four-beat memory burst. On a load cycle it takes a full external address and presents it unchanged as the first beat. On each later continue cycle it steps an internal two-bit beat counter and presents a new address. The upper address bits keep the values from the load. The two low bits follow one of two orders, chosen by a static mode input.

In interleaved order the low bits are the starting low bits XORed with the beat count. In linear order they are the starting low bits plus the beat count, modulo four. Either way, the sequence comes back to the starting address after four beats and then repeats.

A clock enable input freezes the whole sequencer: while it is low, neither a load nor a continue has any effect. The output is registered, so each new address appears one clock after the cycle that requested it. Command decode and the storage array sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high, and after it is released until the first enabled cycle, `addr_o` is all zeros and the beat count is 0.
- R2: An enabled cycle with `load_i`=1 places `addr_i` on `addr_o` after the next rising edge and resets the beat count to 0.
- R3: With `ilv_mode_i`=1 (interleaved), each enabled cycle with `load_i`=0 advances the count, and `addr_o[1:0]` becomes start XOR count. For example, start 2'b10 gives 10, 11, 00, 01.
- R4: With `ilv_mode_i`=0 (linear), each continue cycle makes `addr_o[1:0]` equal to (start + count) mod 4. For example, start 2'b11 gives 11, 00, 01, 10.
- R5: The beat count is two bits wide. After four continue cycles, `addr_o` again equals the loaded address, and the sequence then repeats.
- R6: On a continue cycle, `addr_o[ADDR_W-1:2]` keeps its value from the load. No carry ever passes from the low bits into the upper bits.
- R7: A cycle with `step_en_i`=0 leaves `addr_o` and the beat count unchanged, whatever `load_i` and `addr_i` are. The next continue resumes at the following beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en_i | input | 1 | Clock enable; 0 freezes the sequencer |
| load_i | input | 1 | 1 = load a new start address, 0 = continue the burst |
| ilv_mode_i | input | 1 | Order select: 1 = interleaved (XOR), 0 = linear (add mod 4) |
| addr_i | input | ADDR_W | External start address, sampled on enabled load cycles |
| addr_o | output | ADDR_W | Registered current burst address |

## Verification
The bench sweeps all four starting low-bit values in both orders. It uses several upper-bit patterns, including all ones, and runs six continue beats per burst. This exercises the wrap back to the start and exposes any carry into the upper bits; a design that added without masking would corrupt bit 2 whenever the start is 2'b11 in linear mode. The bench places disabled cycles in the middle of bursts, some of them asserting load with a different address. A design that ignored the enable would either skip a beat or pick up the stray address. The bench also reloads in the middle of a burst and checks that the count restarts at zero rather than continuing from the old beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LOW_W = 2;
  typedef logic [LOW_W-1:0] low_t;

  // Low address bits for a beat, given the start low bits and the beat count.
  function automatic low_t order_low(input low_t start, input low_t cnt, input logic ilv);
    low_t r;
    if (ilv) r = start ^ cnt;
    else     r = start + cnt;
    return r;
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic load,
  input  low_t start_in,
  output low_t start_q,
  output low_t cnt_nxt
);
  low_t cnt_q;

  assign cnt_nxt = load ? '0 : low_t'(cnt_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      start_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_nxt;
      if (load) start_q <= start_in;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  low_t start,
  input  low_t cnt,
  input  logic ilv,
  output low_t low_out
);
  assign low_out = order_low(start, cnt, ilv);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en_i,
  input  logic              load_i,
  input  logic              ilv_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - LOW_W;

  low_t start_q;
  low_t cnt_nxt;
  low_t low_nxt;

  burst_beat_ctr ctr_i (
    .clk      (clk),
    .rst      (rst),
    .en       (step_en_i),
    .load     (load_i),
    .start_in (addr_i[LOW_W-1:0]),
    .start_q  (start_q),
    .cnt_nxt  (cnt_nxt)
  );

  burst_order_map map_i (
    .start   (start_q),
    .cnt     (cnt_nxt),
    .ilv     (ilv_mode_i),
    .low_out (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
    end else if (step_en_i) begin
      if (load_i) addr_o <= addr_i;
      else        addr_o <= {addr_o[ADDR_W-1 -: UP_W], low_nxt};
    end
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              step_en_i,
  input logic              load_i,
  input logic              ilv_mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic [1:0] s_q;
  logic [1:0] c_q;
  logic       mode_q;
  logic       clean_q;

  // Independent tracking of start, beat and whether the mode stayed fixed.
  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= '0; c_q <= '0; mode_q <= ilv_mode_i; clean_q <= 1'b0;
    end else if (step_en_i) begin
      mode_q <= ilv_mode_i;
      if (load_i) begin
        s_q <= addr_i[1:0]; c_q <= '0; clean_q <= 1'b1;
      end else begin
        c_q <= c_q + 2'd1;
        if (ilv_mode_i != mode_q) clean_q <= 1'b0;
      end
    end
  end

  logic ok_step;
  assign ok_step = clean_q && (ilv_mode_i == mode_q);

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> addr_o == '0);
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    step_en_i && load_i |=> addr_o == $past(addr_i));
  assert_ilv_order_R3: assert property (@(posedge clk) disable iff (rst)
    step_en_i && !load_i && ilv_mode_i && ok_step |=> addr_o[1:0] == (s_q ^ c_q));
  assert_lin_order_R4: assert property (@(posedge clk) disable iff (rst)
    step_en_i && !load_i && !ilv_mode_i && ok_step |=> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1);
  assert_wrap_start_R5: assert property (@(posedge clk) disable iff (rst)
    step_en_i && !load_i && ok_step && c_q == 2'd3 |=> addr_o[1:0] == s_q);
  assert_upper_kept_R6: assert property (@(posedge clk) disable iff (rst)
    step_en_i && !load_i |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !step_en_i |=> $stable(addr_o));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  localparam int AW = 8;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          step_en_i;
  logic          load_i;
  logic          ilv_mode_i;
  logic [AW-1:0] addr_i;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [AW-3:0] m_up;
  logic [1:0]    m_s;
  logic [1:0]    m_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .step_en_i(step_en_i), .load_i(load_i),
    .ilv_mode_i(ilv_mode_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  function automatic logic [AW-1:0] expect_addr();
    logic [1:0] lo;
    if (ilv_mode_i) lo = m_s ^ m_c;
    else            lo = 2'((int'(m_s) + int'(m_c)) % 4);
    return {m_up, lo};
  endfunction

  task automatic check(input string req);
    logic [AW-1:0] e;
    e = expect_addr();
    n_chk++;
    if (addr_o !== e) begin
      n_bad++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, e);
    end
  endtask

  // One cycle: drive at negedge, update model, sample shortly after posedge.
  task automatic cycle(input logic en, input logic ld, input logic [AW-1:0] a, input string req);
    @(negedge clk);
    step_en_i = en; load_i = ld; addr_i = a;
    @(posedge clk);
    if (en) begin
      if (ld) begin m_up = a[AW-1:2]; m_s = a[1:0]; m_c = 2'd0; end
      else    m_c = m_c + 2'd1;
    end
    #1;
    check(req);
  endtask

  initial begin
    rst = 1'b1; step_en_i = 1'b0; load_i = 1'b0; ilv_mode_i = 1'b1; addr_i = '0;
    m_up = '0; m_s = '0; m_c = '0;
    repeat (3) @(posedge clk);
    #1; check("R1");
    @(negedge clk); rst = 1'b0;
    // R1: continue from reset starts from address zero
    cycle(1'b0, 1'b1, 8'hA5, "R1_R7");
    cycle(1'b1, 1'b0, 8'h00, "R1_R3");

    for (int m = 0; m < 2; m++) begin
      for (int u = 0; u < 3; u++) begin
        for (int s = 0; s < 4; s++) begin
          logic [AW-3:0] up;
          up = (u == 0) ? '0 : (u == 1) ? '1 : 6'h2A;
          @(negedge clk); ilv_mode_i = (m == 0);
          cycle(1'b1, 1'b1, {up, 2'(s)}, "R2");
          for (int b = 0; b < 6; b++) begin
            if (b == 2) begin
              // R7: disabled cycle with a stray load must not disturb anything
              cycle(1'b0, 1'b1, ~{up, 2'(s)}, "R7");
              cycle(1'b0, 1'b0, 8'h00, "R7");
            end
            cycle(1'b1, 1'b0, 8'h00,
                  (b == 3) ? "R5" : (m == 0) ? "R3_R6" : "R4_R6");
          end
        end
      end
    end

    // R2: reload mid-burst restarts the count
    @(negedge clk); ilv_mode_i = 1'b0;
    cycle(1'b1, 1'b1, 8'h37, "R2");
    cycle(1'b1, 1'b0, 8'h00, "R4");
    cycle(1'b1, 1'b1, 8'hC6, "R2");
    cycle(1'b1, 1'b0, 8'h00, "R4");
    cycle(1'b1, 1'b0, 8'h00, "R6");

    // R1: reset mid-burst clears output
    @(negedge clk); rst = 1'b1; step_en_i = 1'b1; load_i = 1'b0;
    @(posedge clk); m_up = '0; m_s = '0; m_c = '0; #1; check("R1");
    @(negedge clk); rst = 1'b0;

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule